// File: doc/BRIEF.md
# Predicated Vector Add-Across-Lanes Unit

The block reduces a 16-byte vector into one 32-bit scalar. The vector is split into elements of 8, 16 or 32 bits. Each element is sign-extended or zero-extended to 32 bits. The active elements are then added in turn to a starting value.

A per-byte predicate mask selects the elements that take part. The starting value is either the incoming scalar or zero. A resume indication forces the incoming scalar to be used. This lets a reduction that was interrupted before its first beat carry on from the partial sum it had reached.

A request is accepted in any cycle in which `in_valid` is high. The registered result appears one cycle later, marked by a single-cycle `out_valid` pulse. A request with the reserved size code is rejected: it raises `out_illegal` instead of producing a result.

Top module: `lane_sum_reducer`

## Requirements
- R1: With `in_size`=0 (8-bit elements), the result is the start value plus every byte lane i (0..15) whose mask bit i is 1.
- R2: With `in_size`=1 (16-bit elements), halfword lane i (0..7) takes part when mask bit 2i is 1.
- R3: With `in_size`=2 (32-bit elements), word lane i (0..3) takes part when mask bit 4i is 1.
- R4: `in_size`=3 is reserved. It gives a one-cycle `out_illegal` pulse, no `out_valid`, and leaves `out_result` unchanged.
- R5: When `in_unsigned`=0, each element is sign-extended before the add. When `in_unsigned`=1, each element is zero-extended.
- R6: When `in_accum`=1, the sum starts from `in_scalar`. When `in_accum`=0 and `in_resume`=0, the sum starts from zero.
- R7: When `in_resume`=1, the sum starts from `in_scalar` even if `in_accum`=0.
- R8: The addition wraps modulo 2^32. There is no saturation.
- R9: A legal request with an all-zero mask returns the start value unchanged.
- R10: After reset, `out_valid`, `out_illegal` and `out_result` are 0. A request accepted at one edge gives exactly one `out_valid` (or `out_illegal`) cycle after the next edge. `in_ready` is always 1.
- R11: Mask bits that do not address the lowest byte of an element have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted (always 1) |
| in_vec | input | 128 | Vector operand, lane 0 in the low bits |
| in_scalar | input | 32 | Incoming scalar |
| in_size | input | 2 | Element size: 0=8, 1=16, 2=32 bits, 3 reserved |
| in_unsigned | input | 1 | 1 = zero-extend elements, 0 = sign-extend |
| in_accum | input | 1 | 1 = start the sum from `in_scalar` |
| in_mask | input | 16 | Per-byte predicate |
| in_resume | input | 1 | Resumed after a skipped first beat; forces start from `in_scalar` |
| out_valid | output | 1 | Result pulse |
| out_result | output | 32 | Registered sum |
| out_illegal | output | 1 | Reserved-size pulse |

## Verification
The bench builds the block with the default vector width of 16 bytes. This default gives sixteen byte lanes, eight halfword lanes and four word lanes, so every lane position in every size is reachable through the mask. Random vectors and masks are mixed with all-ones elements, which drive the sign-versus-zero extension difference and the 2^32 wrap. Directed cases cover the empty mask, the resume start, and reserved-size requests inserted between legal results.

// File: rtl/lane_sum_reducer.sv
module lane_sum_reducer #(
  parameter int VEC_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [8*VEC_BYTES-1:0] in_vec,
  input  logic [31:0]            in_scalar,
  input  logic [1:0]             in_size,
  input  logic                   in_unsigned,
  input  logic                   in_accum,
  input  logic [VEC_BYTES-1:0]   in_mask,
  input  logic                   in_resume,
  output logic                   out_valid,
  output logic [31:0]            out_result,
  output logic                   out_illegal
);
  localparam int N8  = VEC_BYTES;
  localparam int N16 = VEC_BYTES / 2;
  localparam int N32 = VEC_BYTES / 4;

  logic        legal;
  logic [31:0] start, s8, s16, s32, sum;

  assign in_ready = 1'b1;
  assign legal    = (in_size != 2'd3);
  assign start    = (in_accum || in_resume) ? in_scalar : 32'd0;

  always_comb begin
    s8 = start;
    for (int i = 0; i < N8; i++)
      if (in_mask[i])
        s8 = s8 + {{24{in_vec[8*i+7] & ~in_unsigned}}, in_vec[8*i +: 8]};
  end

  always_comb begin
    s16 = start;
    for (int i = 0; i < N16; i++)
      if (in_mask[2*i])
        s16 = s16 + {{16{in_vec[16*i+15] & ~in_unsigned}}, in_vec[16*i +: 16]};
  end

  always_comb begin
    s32 = start;
    for (int i = 0; i < N32; i++)
      if (in_mask[4*i])
        s32 = s32 + in_vec[32*i +: 32];
  end

  always_comb begin
    case (in_size)
      2'd0:    sum = s8;
      2'd1:    sum = s16;
      default: sum = s32;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= 32'd0;
    end else begin
      out_valid   <= in_valid && legal;
      out_illegal <= in_valid && !legal;
      if (in_valid && legal) out_result <= sum;
    end
  end
endmodule

// File: rtl/lane_sum_reducer_chk.sv
module lane_sum_reducer_chk #(
  parameter int VEC_BYTES = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [31:0]          in_scalar,
  input logic [1:0]           in_size,
  input logic                 in_accum,
  input logic [VEC_BYTES-1:0] in_mask,
  input logic                 in_resume,
  input logic                 out_valid,
  input logic [31:0]          out_result,
  input logic                 out_illegal
);
  AST_ACCEPT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_size != 2'd3 |=> out_valid && !out_illegal); // R10
  AST_RESERVED_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_size == 2'd3 |=> out_illegal && !out_valid && $stable(out_result)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_illegal && $stable(out_result)); // R10
  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_size != 2'd3 && in_mask == '0 && (in_accum || in_resume)
      |=> out_result == $past(in_scalar)); // R9
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_size != 2'd3 && in_mask == '0 && !in_accum && !in_resume
      |=> out_result == 32'd0); // R6
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_ready); // R10
endmodule

bind lane_sum_reducer lane_sum_reducer_chk #(.VEC_BYTES(VEC_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_scalar(in_scalar), .in_size(in_size), .in_accum(in_accum),
  .in_mask(in_mask), .in_resume(in_resume), .out_valid(out_valid),
  .out_result(out_result), .out_illegal(out_illegal));

// File: tb/lane_sum_reducer_test.sv
module lane_sum_reducer_test;
  logic         clk = 0, rst_n = 0;
  logic         in_valid = 0, in_ready;
  logic [127:0] in_vec = '0;
  logic [31:0]  in_scalar = '0;
  logic [1:0]   in_size = '0;
  logic         in_unsigned = 0, in_accum = 0, in_resume = 0;
  logic [15:0]  in_mask = '0;
  logic         out_valid, out_illegal;
  logic [31:0]  out_result;
  int           n_chk = 0, n_bad = 0;
  bit           done = 0;

  always #2.5 clk = ~clk;

  lane_sum_reducer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_vec(in_vec), .in_scalar(in_scalar), .in_size(in_size),
    .in_unsigned(in_unsigned), .in_accum(in_accum), .in_mask(in_mask),
    .in_resume(in_resume), .out_valid(out_valid), .out_result(out_result),
    .out_illegal(out_illegal));

  function automatic logic [31:0] model(logic [127:0] v, logic [31:0] sc,
      logic [1:0] sz, logic u, logic acc, logic [15:0] m, logic res);
    logic [31:0] s = (acc || res) ? sc : 32'd0;
    int eb = 1 << sz;
    for (int e = 0; e < 16 / eb; e++) begin
      if (m[e*eb]) begin
        if (sz == 0)      s += u ? {24'd0, v[8*e +: 8]}  : {{24{v[8*e+7]}}, v[8*e +: 8]};
        else if (sz == 1) s += u ? {16'd0, v[16*e +: 16]} : {{16{v[16*e+15]}}, v[16*e +: 16]};
        else              s += v[32*e +: 32];
      end
    end
    return s;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(string req, logic [127:0] v, logic [31:0] sc, logic [1:0] sz,
      logic u, logic acc, logic [15:0] m, logic res);
    logic [31:0] prev, exp;
    prev = out_result;
    exp  = (sz == 3) ? prev : model(v, sc, sz, u, acc, m, res);
    @(negedge clk);
    in_valid = 1; in_vec = v; in_scalar = sc; in_size = sz;
    in_unsigned = u; in_accum = acc; in_mask = m; in_resume = res;
    @(negedge clk);
    in_valid = 0;
    check({req, " valid"}, {31'd0, out_valid}, {31'd0, sz != 3});
    check({req, " illegal"}, {31'd0, out_illegal}, {31'd0, sz == 3});
    check({req, " result"}, out_result, exp);
    @(negedge clk);
    check({req, " R10 single pulse"}, {30'd0, out_valid, out_illegal}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check("R10 reset valid", {31'd0, out_valid}, 32'd0);
    check("R10 reset illegal", {31'd0, out_illegal}, 32'd0);
    check("R10 reset result", out_result, 32'd0);
    check("R10 ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1;
    // R1 all byte lanes signed -1 each: 16 * -1
    run("R1", {128{1'b1}}, 32'd0, 0, 0, 0, 16'hFFFF, 0);
    // R5 unsigned bytes 0xFF * 16
    run("R5", {128{1'b1}}, 32'd0, 0, 1, 0, 16'hFFFF, 0);
    // R5 signed/unsigned halfwords
    run("R5", {128{1'b1}}, 32'd10, 1, 0, 1, 16'hFFFF, 0);
    run("R5", {128{1'b1}}, 32'd10, 1, 1, 1, 16'hFFFF, 0);
    // R2 only odd-mask bits set -> nothing taken (R11)
    run("R11", {128{1'b1}}, 32'd7, 1, 1, 1, 16'hAAAA, 0);
    // R3 word lanes, bits not at 4i ignored (R11)
    run("R11", {32'd4, 32'd3, 32'd2, 32'd1}, 32'd0, 2, 0, 0, 16'hEEEE, 0);
    run("R3", {32'd4, 32'd3, 32'd2, 32'd1}, 32'd0, 2, 0, 0, 16'h0101, 0);
    // R8 wrap
    run("R8", {4{32'hFFFF_FFFF}}, 32'h0000_0005, 2, 1, 1, 16'hFFFF, 0);
    // R6 accumulate off ignores scalar; R7 resume uses it
    run("R6", {16{8'h01}}, 32'd1000, 0, 1, 0, 16'h00FF, 0);
    run("R7", {16{8'h01}}, 32'd1000, 0, 1, 0, 16'h00FF, 1);
    // R9 empty mask
    run("R9", {128{1'b1}}, 32'hDEAD_BEEF, 1, 0, 1, 16'h0000, 0);
    run("R9", {128{1'b1}}, 32'hDEAD_BEEF, 2, 0, 0, 16'h0000, 0);
    // R4 reserved size keeps result
    run("R4", {128{1'b1}}, 32'h1234, 3, 0, 1, 16'hFFFF, 0);
    for (int k = 0; k < 400; k++) begin
      logic [1:0] sz = 2'($urandom_range(0, 3));
      string tag;
      tag = (sz == 0) ? "R1" : (sz == 1) ? "R2" : (sz == 2) ? "R3" : "R4";
      run(tag, {$urandom, $urandom, $urandom, $urandom}, $urandom, sz,
          1'($urandom), 1'($urandom), 16'($urandom), 1'($urandom_range(0, 3) == 0));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule